// File: doc/BRIEF.md
# Register Rename Table

This block gives each architectural register name a physical storage location so that instructions that only reuse a name no longer wait on each other. Two parts hold the state. The map table is indexed by architectural name and holds the physical location of that name's most recent writer. The free list is a circular FIFO of locations that nothing currently holds.

Each accepted instruction has both source names translated through the current mapping. If it writes a register, its destination then takes the location at the head of the free list, and the map table records that location for the destination name. A consumer therefore still names its producer's location, so true read-after-write dependences are kept.

Another part of the pipeline returns locations through the release port once no reader can still need them. Their tags are pushed at the tail of the free list. At reset name k maps to location k. The locations from `ARCH_REGS` to `PHYS_REGS-1` start on the free list in ascending order.

Requests use a valid/ready handshake. An instruction is accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` falls only when the free list is empty and the offered instruction has a destination. The sender must then hold the request until `in_ready` rises again. `stall` flags that condition while a request is offered. The response side has no back-pressure: a result appears for exactly one cycle. The release port is always accepted.

Top module: `rn_rename`

## Requirements
- R1: After reset, architectural name k maps to physical location k for every name.
- R2: The source tags of an accepted instruction equal the locations most recently assigned to those names by earlier accepted instructions.
- R3: An accepted instruction with a destination receives the location at the head of the free list. After reset the free list hands out `ARCH_REGS`, `ARCH_REGS+1`, … `PHYS_REGS-1` in that order.
- R4: Sources are translated before the same instruction's destination is remapped. A source naming the instruction's own destination gets the old location.
- R5: An accepted instruction without a destination pops nothing from the free list and reports `out_has_dst`=0 with `out_dst_tag`=0.
- R6: With the free list empty and `in_has_dst`=1, `in_ready` is 0 and `stall` equals `in_valid`. The map table and the free list are not changed by that request.
- R7: An instruction without a destination is accepted even when the free list is empty.
- R8: Released locations are handed out again in the order they were released, after all locations already on the list.
- R9: A release and an allocation in the same cycle are both carried out. A location released while the list is empty can be allocated from the next cycle on.
- R10: `out_valid` is 1 in exactly the cycle after an accepting edge, and 0 otherwise.
- R11: During and right after reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction can be accepted this cycle |
| in_src0 | input | $clog2(ARCH_REGS) | First source name |
| in_src1 | input | $clog2(ARCH_REGS) | Second source name |
| in_has_dst | input | 1 | Instruction writes a register |
| in_dst | input | $clog2(ARCH_REGS) | Destination name |
| rel_valid | input | 1 | Return a location to the free list |
| rel_tag | input | $clog2(PHYS_REGS) | Location being returned |
| out_valid | output | 1 | Renamed result present |
| out_src0_tag | output | $clog2(PHYS_REGS) | Location for first source |
| out_src1_tag | output | $clog2(PHYS_REGS) | Location for second source |
| out_has_dst | output | 1 | Result carries a new destination |
| out_dst_tag | output | $clog2(PHYS_REGS) | Newly allocated location, 0 when none |
| stall | output | 1 | Offered instruction blocked by an empty free list |

## Verification
`in_ready` and `stall` depend combinationally on the offered request and the free-list count. The bench reads them 1 ns after it drives the inputs, before the edge. The renamed tags and `out_valid` are registered. They are due one edge after acceptance, so the bench samples them 1 ns after that rising edge. A mapping or release made at one edge first affects the request offered in the following cycle. The bench's reference model applies each update only after it has computed the expected values of the current request, which keeps to this order.

// File: rtl/rn_pkg.sv
package rn_pkg;
  typedef enum logic [1:0] {
    FL_IDLE = 2'b00,
    FL_POP  = 2'b01,
    FL_PUSH = 2'b10,
    FL_BOTH = 2'b11
  } fl_op_e;
endpackage

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int ARCH_REGS = 8,
  parameter int PHYS_REGS = 16,
  localparam int AW = $clog2(ARCH_REGS),
  localparam int PW = $clog2(PHYS_REGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd0_idx,
  input  logic [AW-1:0] rd1_idx,
  output logic [PW-1:0] rd0_tag,
  output logic [PW-1:0] rd1_tag,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [PW-1:0] wr_tag
);
  logic [PW-1:0] entry_q [ARCH_REGS];

  for (genvar k = 0; k < ARCH_REGS; k++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n)
        entry_q[k] <= PW'(k);
      else if (wr_en && (wr_idx == AW'(k)))
        entry_q[k] <= wr_tag;
    end
  end

  // Reads see state before this cycle's write: old mapping for sources.
  assign rd0_tag = entry_q[rd0_idx];
  assign rd1_tag = entry_q[rd1_idx];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (entry_q[$past(wr_idx)] == $past(wr_tag))); // R3
  AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (entry_q[$past(rd0_idx)] == $past(rd0_tag))); // R6
endmodule

// File: rtl/rn_free_list.sv
module rn_free_list #(
  parameter int ARCH_REGS = 8,
  parameter int PHYS_REGS = 16,
  localparam int PW    = $clog2(PHYS_REGS),
  localparam int DEPTH = PHYS_REGS - ARCH_REGS,
  localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop,
  output logic [PW-1:0] head_tag,
  output logic          empty,
  input  logic          push,
  input  logic [PW-1:0] push_tag
);
  import rn_pkg::*;

  logic [PW-1:0] slot_q [DEPTH];
  logic [IW-1:0] head_q, tail_q;
  logic [CW-1:0] cnt_q;
  logic          full;
  fl_op_e        op;

  function automatic logic [IW-1:0] wrap_inc(input logic [IW-1:0] p);
    return (p == IW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign op       = fl_op_e'({push, pop});
  assign empty    = (cnt_q == '0);
  assign full     = (cnt_q == CW'(DEPTH));
  assign head_tag = slot_q[head_q];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        slot_q[i] <= PW'(ARCH_REGS + i);
      else if (push && (tail_q == IW'(i)))
        slot_q[i] <= push_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= CW'(DEPTH);
    end else begin
      case (op)
        FL_POP: begin
          head_q <= wrap_inc(head_q);
          cnt_q  <= cnt_q - 1'b1;
        end
        FL_PUSH: begin
          tail_q <= wrap_inc(tail_q);
          cnt_q  <= cnt_q + 1'b1;
        end
        FL_BOTH: begin
          head_q <= wrap_inc(head_q);
          tail_q <= wrap_inc(tail_q);
        end
        default: ;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |-> !full); // R8
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R6
  AST_COUNT_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> (cnt_q == $past(cnt_q))); // R9
  AST_PUSH_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (slot_q[$past(tail_q)] == $past(push_tag))); // R8
endmodule

// File: rtl/rn_rename.sv
module rn_rename #(
  parameter int ARCH_REGS = 8,
  parameter int PHYS_REGS = 16,
  localparam int AW = $clog2(ARCH_REGS),
  localparam int PW = $clog2(PHYS_REGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] in_src0,
  input  logic [AW-1:0] in_src1,
  input  logic          in_has_dst,
  input  logic [AW-1:0] in_dst,
  input  logic          rel_valid,
  input  logic [PW-1:0] rel_tag,
  output logic          out_valid,
  output logic [PW-1:0] out_src0_tag,
  output logic [PW-1:0] out_src1_tag,
  output logic          out_has_dst,
  output logic [PW-1:0] out_dst_tag,
  output logic          stall
);
  logic          fl_empty;
  logic [PW-1:0] fl_head;
  logic [PW-1:0] src0_map, src1_map;
  logic          accept, alloc;

  assign in_ready = !(in_has_dst && fl_empty);
  assign stall    = in_valid && !in_ready;
  assign accept   = in_valid && in_ready;
  assign alloc    = accept && in_has_dst;

  rn_map_table #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) u_map (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd0_idx (in_src0),
    .rd1_idx (in_src1),
    .rd0_tag (src0_map),
    .rd1_tag (src1_map),
    .wr_en   (alloc),
    .wr_idx  (in_dst),
    .wr_tag  (fl_head)
  );

  rn_free_list #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) u_free (
    .clk      (clk),
    .rst_n    (rst_n),
    .pop      (alloc),
    .head_tag (fl_head),
    .empty    (fl_empty),
    .push     (rel_valid),
    .push_tag (rel_tag)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_src0_tag <= '0;
      out_src1_tag <= '0;
      out_has_dst  <= 1'b0;
      out_dst_tag  <= '0;
    end else begin
      out_valid <= accept;
      if (accept) begin
        out_src0_tag <= src0_map;
        out_src1_tag <= src1_map;
        out_has_dst  <= in_has_dst;
        out_dst_tag  <= in_has_dst ? fl_head : '0;
      end
    end
  end

  AST_RESP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid); // R10
  AST_NO_RESP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !out_valid); // R10
  AST_STALL_NO_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !out_valid); // R6
  AST_NODST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_has_dst) |-> (out_dst_tag == '0)); // R5
  AST_NODST_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !in_has_dst |-> in_ready); // R7
endmodule

// File: tb/rn_rename_test.sv
module rn_rename_test;
  localparam int A  = 8;
  localparam int P  = 16;
  localparam int AW = $clog2(A);
  localparam int PW = $clog2(P);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_has_dst = 1'b0, rel_valid = 1'b0;
  logic [AW-1:0] in_src0 = '0, in_src1 = '0, in_dst = '0;
  logic [PW-1:0] rel_tag = '0;
  logic in_ready, out_valid, out_has_dst, stall;
  logic [PW-1:0] out_src0_tag, out_src1_tag, out_dst_tag;

  int checks = 0, fails = 0, cycles = 0;
  int map_m [A];
  int fq[$];
  int retired[$];

  always #2 clk = ~clk;

  rn_rename #(.ARCH_REGS(A), .PHYS_REGS(P)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_src0(in_src0), .in_src1(in_src1), .in_has_dst(in_has_dst),
    .in_dst(in_dst), .rel_valid(rel_valid), .rel_tag(rel_tag),
    .out_valid(out_valid), .out_src0_tag(out_src0_tag),
    .out_src1_tag(out_src1_tag), .out_has_dst(out_has_dst),
    .out_dst_tag(out_dst_tag), .stall(stall)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic do_cycle(input bit v, input int s0, input int s1, input bit hd,
                          input int d, input bit rv, input int rt, input string tg);
    bit exp_rdy, acc;
    int e0, e1, ed;
    in_valid = v; in_src0 = AW'(s0); in_src1 = AW'(s1);
    in_has_dst = hd; in_dst = AW'(d);
    rel_valid = rv; rel_tag = PW'(rt);
    #1;
    exp_rdy = !(hd && fq.size() == 0);
    check("R6 ready", int'(in_ready), int'(exp_rdy));
    check("R6 stall", int'(stall), int'(v && !exp_rdy));
    acc = v && exp_rdy;
    e0 = map_m[s0]; e1 = map_m[s1]; ed = 0;
    if (acc && hd) begin
      ed = fq.pop_front();
      retired.push_back(map_m[d]);
      map_m[d] = ed;
    end
    if (rv) fq.push_back(rt);
    @(posedge clk); #1;
    check("R10 out_valid", int'(out_valid), int'(acc));
    if (acc) begin
      check({tg, " src0"}, int'(out_src0_tag), e0);
      check({tg, " src1"}, int'(out_src1_tag), e1);
      check({tg, " has_dst"}, int'(out_has_dst), int'(hd));
      check({tg, " dst"}, int'(out_dst_tag), ed);
    end
    @(negedge clk);
    in_valid = 1'b0; rel_valid = 1'b0;
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++;
        $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
      end
    end
  end

  initial begin : stim
    int rt;
    void'($urandom(32'd20240917));
    for (int k = 0; k < A; k++) map_m[k] = k;
    for (int k = A; k < P; k++) fq.push_back(k);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R11 in_ready", int'(in_ready), 1);
    check("R11 out_valid", int'(out_valid), 0);
    @(negedge clk);

    // R1: identity mapping, read without destinations
    for (int k = 0; k < A; k++) do_cycle(1, k, (k + 1) % A, 0, 0, 0, 0, "R1");

    // R3: first allocation takes A; R4: sources read old mapping
    do_cycle(1, 0, 2, 1, 1, 0, 0, "R3");
    do_cycle(1, 1, 3, 1, 2, 0, 0, "R4");
    do_cycle(1, 3, 3, 1, 3, 0, 0, "R4");
    // R5: no destination leaves the free list alone
    do_cycle(1, 2, 3, 0, 5, 0, 0, "R5");
    do_cycle(1, 2, 1, 1, 4, 0, 0, "R5");

    // Drain the free list
    while (fq.size() > 0) do_cycle(1, 4, 5, 1, 6, 0, 0, "R2");
    // R6: stall, nothing changes
    do_cycle(1, 6, 1, 1, 7, 0, 0, "R6");
    do_cycle(1, 7, 6, 0, 0, 0, 0, "R6");
    // R7: no-destination instruction still accepted
    do_cycle(1, 3, 2, 0, 0, 0, 0, "R7");
    // R9: release while empty: stalled now, allocatable next cycle
    rt = retired.pop_front();
    do_cycle(1, 0, 0, 1, 0, 1, rt, "R9");
    rt = retired.pop_front();
    do_cycle(1, 0, 1, 1, 0, 1, rt, "R9");
    do_cycle(1, 0, 1, 1, 5, 0, 0, "R9");
    // R8: releases come back in FIFO order
    for (int k = 0; k < 3; k++) begin
      rt = retired.pop_front();
      do_cycle(0, 0, 0, 0, 0, 1, rt, "R8");
    end
    for (int k = 0; k < 3; k++) do_cycle(1, k, 7, 1, k, 0, 0, "R8");

    // Constrained random traffic
    for (int n = 0; n < 3000; n++) begin
      bit v, hd, rv;
      v  = ($urandom % 4) != 0;
      hd = ($urandom % 10) < 7;
      rv = (retired.size() > 0) && (($urandom % 3) == 0);
      rt = rv ? retired.pop_front() : 0;
      do_cycle(v, $urandom % A, $urandom % A, hd, $urandom % A, rv, rt, "R2");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule